// File: doc/BRIEF.md
# Four-Line Interrupt Combiner with Slot Routing

This block collects four interrupt request lines, such as the four shared request lines of a host bridge, into a single 32-bit control word. Each line has a sticky pending flag and an enable flag in that word. The OR of all pending-and-enabled lines drives one registered request output to a parent interrupt controller. A rising edge on a line sets its pending flag, so both one-cycle pulses and held levels are accepted.

Software reads the whole word at once. It writes through a 32-bit port with four byte enables. Pending flags are cleared by writing a 1 to them, and a 0 written to a pending flag leaves it alone. This lets software change enables without acknowledging pending events. A single write to the upper halfword of 0xF000 masks and clears every line.

A separate combinational routing function maps a device slot number and a request pin onto one of the four line indices. It uses a rotation, so that the four slots spread their first pins across different lines. It raises a valid flag only for a legal slot and pin.

Top module: `irq_combiner`

## Requirements
- R1: A rising edge on `src_i[k]`, for k from 0 to 3, sets pending flag bit 28+k of the control word at the next clock edge. This happens whether line k is enabled or not.
- R2: A pending flag stays set until software clears it.
- R3: A write with `wr_be[3]` high and a 1 in data bit 28+k clears pending flag k. A 0 in that bit, or `wr_be[3]` low, leaves the flag unchanged.
- R4: If a rising edge on line k and a clear of flag k fall in the same cycle, the flag is left set.
- R5: Enable bits sit at 25:22, with bit 22+k for line k (1 = enabled, 0 = masked). They are written through the byte lanes that hold them: lane 3 for bits 25:24 and lane 2 for bits 23:22.
- R6: `irq_o` is a register that equals the OR over k of (pending k AND enable k), taken one clock edge earlier.
- R7: A write with byte enables 4'b1100 and data 0xF000_0000 clears all four pending flags and all four enables in one access. Bits 15:0 are left as they were.
- R8: All other bits of the word (27:26 and 21:0) are plain read/write storage. Each byte lane is written only when its `wr_be` bit is high.
- R9: Reset clears the whole control word and `irq_o`.
- R10: For slot 9 to 12 and pin 1 to 4 (pin 1 to 4 naming request lines A to D), `route_idx` is ((slot-9)+(pin-1)) mod 4 and `route_valid` is 1.
- R11: For a slot outside 9 to 12, or a pin outside 1 to 4, `route_valid` is 0 and `route_idx` is 0.
- R12: A line held high sets its flag once. After a clear it does not set again until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 4 | Interrupt request lines, one per source |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables, bit b covers data bits 8b+7:8b |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| irq_o | output | 1 | Combined request to the parent controller |
| route_slot | input | 8 | Device slot number for routing |
| route_pin | input | 3 | Request pin number, 1 to 4 |
| route_idx | output | 2 | Line index the slot and pin map to |
| route_valid | output | 1 | High when slot and pin are in range |

## Verification
The timing of each result differs. A pending flag appears in `rd_data` after the first clock edge that follows a source edge. `irq_o` lags by one more edge. A register write shows in `rd_data` after its own edge and in `irq_o` one edge later. The routing outputs are combinational. The bench changes inputs on a falling edge and reads on the next falling edge, then waits one more falling edge before it judges `irq_o`. For the router it allows a short settle delay after driving slot and pin.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC      = 4;
  localparam int DW        = 32;
  localparam int BE_W      = DW / 8;
  localparam int ST_LSB    = 28;
  localparam int EN_LSB    = 22;
  localparam int SLOT_W    = 8;
  localparam int PIN_W     = 3;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int SLOT_BASE = 9;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  output logic rise_o
);
  logic src_q;
  logic src_d;

  always_comb src_d = src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src_d;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    rise_i,
  input  logic            wr_en_i,
  input  logic [BE_W-1:0] wr_be_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [N-1:0]    status_o,
  output logic [N-1:0]    enable_o,
  output logic [DW-1:0]   rd_data_o
);
  logic [DW-1:0] word_q;
  logic [DW-1:0] word_d;
  logic [N-1:0]  clr;
  logic          upd;

  // write-one-clear request per source, gated by the lane holding the flag
  always_comb begin
    for (int i = 0; i < N; i++) begin
      clr[i] = wr_en_i && wr_be_i[(ST_LSB + i) / 8] && wr_data_i[ST_LSB + i];
    end
  end

  always_comb begin
    word_d = word_q;
    for (int b = 0; b < BE_W; b++) begin
      if (wr_en_i && wr_be_i[b]) word_d[8*b +: 8] = wr_data_i[8*b +: 8];
    end
    // pending flags: new edge has priority over a clear
    for (int i = 0; i < N; i++) begin
      word_d[ST_LSB + i] = rise_i[i] | (word_q[ST_LSB + i] & ~clr[i]);
    end
  end

  assign upd = wr_en_i | (|rise_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (upd) word_q <= word_d;
  end

  assign status_o  = word_q[ST_LSB +: N];
  assign enable_o  = word_q[EN_LSB +: N];
  assign rd_data_o = word_q;
endmodule

// File: rtl/irqc_route.sv
module irqc_route
  import irqc_pkg::*;
#(
  parameter int SW    = SLOT_W,
  parameter int PW    = PIN_W,
  parameter int IW    = IDX_W,
  parameter int BASE  = SLOT_BASE,
  parameter int LINES = NSRC
) (
  input  logic [SW-1:0] slot_i,
  input  logic [PW-1:0] pin_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  localparam logic [SW:0] LO_SLOT = (SW+1)'(BASE);
  localparam logic [SW:0] HI_SLOT = (SW+1)'(BASE + LINES);
  localparam logic [PW:0] HI_PIN  = (PW+1)'(LINES);

  logic          slot_ok;
  logic          pin_ok;
  logic [IW-1:0] rot;

  always_comb begin
    slot_ok = ({1'b0, slot_i} >= LO_SLOT) && ({1'b0, slot_i} < HI_SLOT);
    pin_ok  = (pin_i != '0) && ({1'b0, pin_i} <= HI_PIN);
    rot     = IW'(slot_i) - IW'(BASE) + IW'(pin_i) - IW'(1);
    valid_o = slot_ok && pin_ok;
    idx_o   = valid_o ? rot : '0;
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              irq_o,
  input  logic [SLOT_W-1:0] route_slot,
  input  logic [PIN_W-1:0]  route_pin,
  output logic [IDX_W-1:0]  route_idx,
  output logic              route_valid
);
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] enable;
  logic            irq_d;
  logic            irq_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_edge
    irqc_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[k]),
      .rise_o (rise[k])
    );
  end

  irqc_regs #(.N(NSRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .wr_en_i   (wr_en),
    .wr_be_i   (wr_be),
    .wr_data_i (wr_data),
    .status_o  (status),
    .enable_o  (enable),
    .rd_data_o (rd_data)
  );

  irqc_route u_route (
    .slot_i  (route_slot),
    .pin_i   (route_pin),
    .idx_o   (route_idx),
    .valid_o (route_valid)
  );

  always_comb irq_d = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_i,
  input logic              wr_en,
  input logic [BE_W-1:0]   wr_be,
  input logic [DW-1:0]     wr_data,
  input logic [DW-1:0]     rd_data,
  input logic              irq_o,
  input logic [SLOT_W-1:0] route_slot,
  input logic [PIN_W-1:0]  route_pin,
  input logic [IDX_W-1:0]  route_idx,
  input logic              route_valid
);
  localparam int CLR_LANE = ST_LSB / 8;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    // R1 R4
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i[k] && !$past(src_i[k])) |=> rd_data[ST_LSB + k]);

    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[ST_LSB + k] && !(wr_en && wr_be[CLR_LANE] && wr_data[ST_LSB + k]))
      |=> rd_data[ST_LSB + k]);

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[CLR_LANE] && wr_data[ST_LSB + k] && !src_i[k])
      |=> !rd_data[ST_LSB + k]);
  end

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_data[ST_LSB +: NSRC] & rd_data[EN_LSB +: NSRC])) |=> irq_o);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(rd_data[ST_LSB +: NSRC] & rd_data[EN_LSB +: NSRC])) |=> !irq_o);

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (rd_data == '0 && !irq_o);
    end
  end

  // R10
  route_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> (route_idx == IDX_W'(int'(route_slot) + int'(route_pin) - SLOT_BASE - 1)));

  // R11
  route_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(route_slot) < SLOT_BASE || int'(route_slot) >= SLOT_BASE + NSRC || route_pin == '0)
    |-> (!route_valid && route_idx == '0));
endmodule

bind irq_combiner irqc_chk u_chk (.*);

// File: tb/sim_irq_combiner.sv
module sim_irq_combiner;
  logic        clk;
  logic        rst_n;
  logic [3:0]  src_i;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq_o;
  logic [7:0]  route_slot;
  logic [2:0]  route_pin;
  logic [1:0]  route_idx;
  logic        route_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_combiner u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o),
    .route_slot(route_slot), .route_pin(route_pin),
    .route_idx(route_idx), .route_valid(route_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // router vectors: {slot, pin, expected idx, expected valid}
  localparam int NV = 14;
  localparam logic [13:0] RT [NV] = '{
    {8'd9,  3'd1, 2'd0, 1'b1}, {8'd9,  3'd4, 2'd3, 1'b1},
    {8'd10, 3'd1, 2'd1, 1'b1}, {8'd10, 3'd4, 2'd0, 1'b1},
    {8'd11, 3'd2, 2'd3, 1'b1}, {8'd11, 3'd3, 2'd0, 1'b1},
    {8'd12, 3'd1, 2'd3, 1'b1}, {8'd12, 3'd2, 2'd0, 1'b1},
    {8'd12, 3'd4, 2'd2, 1'b1}, {8'd8,  3'd1, 2'd0, 1'b0},
    {8'd13, 3'd1, 2'd0, 1'b0}, {8'd10, 3'd0, 2'd0, 1'b0},
    {8'd10, 3'd5, 2'd0, 1'b0}, {8'd0,  3'd1, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    src_i[k] = 1'b1;
    @(negedge clk);
    src_i[k] = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_i = '0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
    route_slot = '0; route_pin = '0;
    repeat (3) @(negedge clk);
    chk("R9 word", rd_data, 32'h0);
    chk("R9 irq", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;

    // router table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      route_slot = RT[v][13:6];
      route_pin  = RT[v][5:3];
      #2;
      if (RT[v][0]) chk("R10 route", {30'b0, route_idx}, {30'b0, RT[v][2:1]});
      else          chk("R11 route", {30'b0, route_idx}, 32'h0);
      chk(RT[v][0] ? "R10 valid" : "R11 valid", {31'b0, route_valid}, {31'b0, RT[v][0]});
    end

    // plain storage by lane
    wr(4'b0001, 32'h0000_00A5);
    chk("R8 lane0", rd_data, 32'h0000_00A5);
    wr(4'b0010, 32'hFFFF_5AFF);
    chk("R8 lane1", rd_data, 32'h0000_5AA5);
    // enable line 0 only via lane 2
    wr(4'b0100, 32'hFF7F_FFFF);
    chk("R5 enable", rd_data, 32'h007F_5AA5);

    // masked line 2 still latches
    pulse(2);
    chk("R1 masked set", rd_data, 32'h407F_5AA5);
    @(negedge clk);
    chk("R6 masked no irq", {31'b0, irq_o}, 32'h0);

    // enabled line 0
    pulse(0);
    chk("R1 set", rd_data, 32'h507F_5AA5);
    chk("R6 not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R6 irq", {31'b0, irq_o}, 32'h1);

    // zeros to flags, and lane 3 off
    wr(4'b1000, 32'h0000_0000);
    chk("R3 zero keeps", rd_data, 32'h507F_5AA5);
    wr(4'b0111, 32'hF07F_5AA5);
    chk("R3 lane off keeps", rd_data, 32'h507F_5AA5);
    repeat (3) @(negedge clk);
    chk("R2 sticky", rd_data, 32'h507F_5AA5);

    // clear line 0
    wr(4'b1000, 32'h1000_0000);
    chk("R3 clear", rd_data, 32'h407F_5AA5);
    @(negedge clk);
    chk("R6 drop", {31'b0, irq_o}, 32'h0);

    // level held on line 1
    @(negedge clk);
    src_i[1] = 1'b1;
    @(negedge clk);
    chk("R12 first set", rd_data, 32'h607F_5AA5);
    wr(4'b1000, 32'h2000_0000);
    chk("R12 cleared", rd_data, 32'h407F_5AA5);
    repeat (2) @(negedge clk);
    chk("R12 held no reset", rd_data, 32'h407F_5AA5);
    src_i[1] = 1'b0;
    @(negedge clk);
    src_i[1] = 1'b1;
    @(negedge clk);
    chk("R12 new edge", rd_data, 32'h607F_5AA5);

    // edge on line 3 together with its clear
    @(negedge clk);
    wr_en = 1'b1; wr_be = 4'b1000; wr_data = 32'hE000_0000; src_i[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
    chk("R4 edge wins", rd_data, 32'h807F_5AA5);

    // enable line 3 through lane 3
    wr(4'b1000, 32'h0200_0000);
    chk("R5 lane3 enable", rd_data, 32'h827F_5AA5);
    @(negedge clk);
    chk("R6 line3 irq", {31'b0, irq_o}, 32'h1);

    // mask and clear all at once
    wr(4'b1100, 32'hF000_0000);
    chk("R7 halfword", rd_data, 32'h0000_5AA5);
    @(negedge clk);
    chk("R7 irq low", {31'b0, irq_o}, 32'h0);

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    src_i = '0;
    @(negedge clk);
    chk("R9 rerun", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule